// File: doc/BRIEF.md
# Task Rendezvous Engine

This unit sits beside a small multitasking processor core and pairs synchronous message requests between numbered tasks. The running task presents a send or a receive along with a partner task number and a timeout counted in scheduler ticks. If the partner is already waiting for it, both tasks are released together with a "delivered" result. If not, the requester is parked until the partner arrives or its timeout runs out. A zero timeout turns the request into a poll that never parks. Naming one's own task number can never match, so it acts as a timed sleep.

The unit keeps one wait slot per task, counts down the timeouts on a tick pulse, and exposes a mask of runnable tasks plus a per-task result code for the scheduler. It also keeps a time-slice down-counter. It asks the scheduler to switch tasks when the slice runs out, when a task parks, or when a task yields on purpose. A task can also query its own number and the ticks left in the current slice.

Top module: `task_rendezvous`

## Requirements
- R1: After reset every task is runnable, every result code is 0, done_o, yield_o and id_valid_o are low, and the slice counter holds SLICE_TICKS.
- R2: Op codes are 0 send, 1 receive, 2 yield, 3 identity query. A send from task A naming B matches if B is parked in a receive that names A or names any (peer code 15). A receive from A naming B matches if B is parked in a send naming A. On a match, both tasks show done_o, runnable_o high and result code 0 on the cycle after the request.
- R3: A send or receive with a nonzero timeout and no ready partner clears the requester's runnable_o bit and pulses yield_o on the cycle after the request.
- R4: A send or receive with timeout 0 and no ready partner never parks. It raises done_o with result 1 (timeout) on the next cycle.
- R5: A task parked with timeout T stays non-runnable through T-1 tick pulses. On the cycle after the T-th tick it becomes runnable with done_o and result 1.
- R6: A request naming its own task number never matches. With timeout T it behaves as a T-tick delay ending with result 1.
- R7: A peer code of 8 to 14, or a send naming peer 15, completes at once with result 2 (invalid) and does not park.
- R8: A receive naming peer 15 matches the lowest-numbered task that is parked sending to the receiver.
- R9: When a match arrives in the same cycle as a parked partner's final tick, the match wins and both tasks report result 0.
- R10: An identity query raises id_valid_o on the next cycle with the requesting task number and the slice ticks left as counted in the request cycle.
- R11: A yield request pulses yield_o on the next cycle and reloads the slice counter.
- R12: With no yield or parking, yield_o pulses on the cycle after the SLICE_TICKS-th tick since the last reload.
- R13: A request presented for a task that is not runnable is ignored. Its mask, results and done flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle scheduler tick pulse |
| req_valid_i | input | 1 | Request strobe from the running task |
| req_op_i | input | 2 | 0 send, 1 receive, 2 yield, 3 identity query |
| req_task_i | input | 3 | Number of the requesting task |
| req_peer_i | input | 4 | Partner task; 15 means any sender (receive only) |
| req_tmo_i | input | 16 | Timeout in ticks; 0 means poll |
| runnable_o | output | 8 | Bit i high when task i may be scheduled |
| done_o | output | 8 | Bit i pulses when task i's request completes |
| status_o | output | 16 | Result of task i in bits [2i+1:2i]: 0 delivered, 1 timeout, 2 invalid |
| yield_o | output | 1 | Pulse asking the scheduler to switch tasks |
| id_valid_o | output | 1 | Identity answer valid |
| id_task_o | output | 3 | Task number returned by the query |
| id_ticks_o | output | 7 | Slice ticks left returned by the query |

## Verification
A wrong slot state appears at the ports within one cycle of the next request that touches that task. A lost wait state shows up as a runnable bit set too early. A wrong stored peer makes a rendezvous fail to produce the paired done_o pulse. A corrupted countdown is exposed at the tick on which the release should occur: the task is released one or more ticks early or late with result 1. A broken slice counter shows up either in the tick count returned by the next identity query or in a yield_o pulse that is missing or misplaced.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
    typedef enum logic [1:0] {
        OP_SEND  = 2'd0,
        OP_RECV  = 2'd1,
        OP_YIELD = 2'd2,
        OP_IDENT = 2'd3
    } rdv_op_e;

    typedef enum logic [1:0] {
        W_NONE = 2'd0,
        W_SEND = 2'd1,
        W_RECV = 2'd2
    } wait_e;

    localparam logic [1:0] RES_OK  = 2'd0;
    localparam logic [1:0] RES_TMO = 2'd1;
    localparam logic [1:0] RES_BAD = 2'd2;
endpackage

// File: rtl/rdv_lowest_pick.sv
module rdv_lowest_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         hit_o
);
    // Lowest index wins: scan from the top so the last hit kept is the lowest.
    always_comb begin
        gnt_o = '0;
        hit_o = 1'b0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req_i[j]) begin
                gnt_o    = '0;
                gnt_o[j] = 1'b1;
                hit_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdv_slice.sv
module rdv_slice #(
    parameter int SLICE_TICKS = 100,
    parameter int SW          = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          restart_i,
    output logic [SW-1:0] count_o,
    output logic          wrap_o
);
    localparam logic [SW-1:0] RELOAD = SW'(SLICE_TICKS);

    logic [SW-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = tick_i && (cnt_q == SW'(1));
        cnt_d  = cnt_q;
        if (restart_i || wrap_o)
            cnt_d = RELOAD;
        else if (tick_i)
            cnt_d = cnt_q - SW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    p_slice_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= RELOAD));

    p_wrap_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == RELOAD));
endmodule

// File: rtl/task_rendezvous.sv
module task_rendezvous
    import rdv_pkg::*;
#(
    parameter int NTASK       = 8,
    parameter int TW          = 16,
    parameter int SLICE_TICKS = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    req_valid_i,
    input  logic [1:0]              req_op_i,
    input  logic [$clog2(NTASK)-1:0] req_task_i,
    input  logic [$clog2(NTASK):0]  req_peer_i,
    input  logic [TW-1:0]           req_tmo_i,
    output logic [NTASK-1:0]        runnable_o,
    output logic [NTASK-1:0]        done_o,
    output logic [2*NTASK-1:0]      status_o,
    output logic                    yield_o,
    output logic                    id_valid_o,
    output logic [$clog2(NTASK)-1:0] id_task_o,
    output logic [$clog2(SLICE_TICKS+1)-1:0] id_ticks_o
);
    localparam int IDW = $clog2(NTASK);
    localparam int PW  = IDW + 1;
    localparam int SW  = $clog2(SLICE_TICKS + 1);
    localparam logic [PW-1:0] PEER_ANY = {PW{1'b1}};

    typedef struct packed {
        wait_e         st;
        logic [PW-1:0] peer;
        logic [TW-1:0] cnt;
    } slot_t;

    typedef struct packed {
        slot_t [NTASK-1:0]  slot;
        logic [NTASK-1:0]   done;
        logic [2*NTASK-1:0] stat;
        logic               yield;
        logic               idv;
        logic [IDW-1:0]     idtask;
        logic [SW-1:0]      idticks;
    } state_t;

    state_t         s_d, s_q;
    logic [NTASK-1:0] cand;
    logic [NTASK-1:0] pick_gnt;
    logic           pick_hit;
    logic           restart;
    logic [SW-1:0]  slice_cnt;
    logic           slice_wrap;
    logic [PW-1:0]  me;
    logic           peer_named, peer_any, peer_bad;

    assign me         = PW'(req_task_i);
    assign peer_named = req_peer_i < PW'(NTASK);
    assign peer_any   = req_peer_i == PEER_ANY;
    assign peer_bad   = (req_op_i == OP_SEND) ? !peer_named : !(peer_named || peer_any);

    // Partners that would complete a rendezvous with the current request.
    always_comb begin
        cand = '0;
        for (int j = 0; j < NTASK; j++) begin
            if (req_op_i == OP_SEND) begin
                if (peer_named && req_peer_i[IDW-1:0] == IDW'(j) &&
                    s_q.slot[j].st == W_RECV &&
                    (s_q.slot[j].peer == me || s_q.slot[j].peer == PEER_ANY))
                    cand[j] = 1'b1;
            end else if (req_op_i == OP_RECV) begin
                if (s_q.slot[j].st == W_SEND && s_q.slot[j].peer == me &&
                    (peer_any || (peer_named && req_peer_i[IDW-1:0] == IDW'(j))))
                    cand[j] = 1'b1;
            end
        end
    end

    rdv_lowest_pick #(.N(NTASK)) pick_i (
        .req_i (cand),
        .gnt_o (pick_gnt),
        .hit_o (pick_hit)
    );

    rdv_slice #(.SLICE_TICKS(SLICE_TICKS), .SW(SW)) slice_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart),
        .count_o   (slice_cnt),
        .wrap_o    (slice_wrap)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = '0;
        s_d.yield = slice_wrap;
        s_d.idv   = 1'b0;
        restart   = 1'b0;

        // Timeout countdown of parked tasks.
        for (int i = 0; i < NTASK; i++) begin
            if (s_q.slot[i].st != W_NONE && tick_i) begin
                if (s_q.slot[i].cnt == TW'(1)) begin
                    s_d.slot[i].st    = W_NONE;
                    s_d.slot[i].cnt   = '0;
                    s_d.done[i]       = 1'b1;
                    s_d.stat[2*i +: 2] = RES_TMO;
                end else begin
                    s_d.slot[i].cnt = s_q.slot[i].cnt - TW'(1);
                end
            end
        end

        // The request is applied after the countdown so a match overrides expiry.
        if (req_valid_i && s_q.slot[req_task_i].st == W_NONE) begin
            case (req_op_i)
                OP_SEND, OP_RECV: begin
                    if (peer_bad) begin
                        s_d.done[req_task_i]           = 1'b1;
                        s_d.stat[2*req_task_i +: 2]    = RES_BAD;
                    end else if (pick_hit) begin
                        for (int j = 0; j < NTASK; j++) begin
                            if (pick_gnt[j]) begin
                                s_d.slot[j].st     = W_NONE;
                                s_d.slot[j].cnt    = '0;
                                s_d.done[j]        = 1'b1;
                                s_d.stat[2*j +: 2] = RES_OK;
                            end
                        end
                        s_d.done[req_task_i]        = 1'b1;
                        s_d.stat[2*req_task_i +: 2] = RES_OK;
                    end else if (req_tmo_i == '0) begin
                        s_d.done[req_task_i]        = 1'b1;
                        s_d.stat[2*req_task_i +: 2] = RES_TMO;
                    end else begin
                        s_d.slot[req_task_i].st   = (req_op_i == OP_SEND) ? W_SEND : W_RECV;
                        s_d.slot[req_task_i].peer = req_peer_i;
                        s_d.slot[req_task_i].cnt  = req_tmo_i;
                        restart   = 1'b1;
                        s_d.yield = 1'b1;
                    end
                end
                OP_YIELD: begin
                    restart   = 1'b1;
                    s_d.yield = 1'b1;
                end
                default: begin
                    s_d.idv     = 1'b1;
                    s_d.idtask  = req_task_i;
                    s_d.idticks = slice_cnt;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NTASK; i++)
            runnable_o[i] = (s_q.slot[i].st == W_NONE);
    end

    assign done_o     = s_q.done;
    assign status_o   = s_q.stat;
    assign yield_o    = s_q.yield;
    assign id_valid_o = s_q.idv;
    assign id_task_o  = s_q.idtask;
    assign id_ticks_o = s_q.idticks;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < NTASK; g++) begin : g_task_chk
        p_release_reported_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(runnable_o[g]) |-> done_o[g]);
        p_done_while_runnable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            done_o[g] |-> runnable_o[g]);
    end

    p_poll_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_op_i[1] && req_tmo_i == '0 && runnable_o[req_task_i])
        |=> done_o[$past(req_task_i)]);

    p_yield_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_YIELD && runnable_o[req_task_i]) |=> yield_o);

    p_ident_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_IDENT && runnable_o[req_task_i])
        |=> (id_valid_o && id_task_o == $past(req_task_i)));

    p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_gnt) && ((pick_gnt & ~cand) == '0));
endmodule

// File: tb/task_rendezvous_tb_top.sv
module task_rendezvous_tb_top;
    localparam int SLICE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_task = '0;
    logic [3:0]  req_peer = '0;
    logic [15:0] req_tmo = '0;
    logic [7:0]  runnable, done;
    logic [15:0] status;
    logic        yield_s, id_valid;
    logic [2:0]  id_task;
    logic [4:0]  id_ticks;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    task_rendezvous #(.NTASK(8), .TW(16), .SLICE_TICKS(SLICE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .req_valid_i(req_valid),
        .req_op_i(req_op), .req_task_i(req_task), .req_peer_i(req_peer),
        .req_tmo_i(req_tmo), .runnable_o(runnable), .done_o(done),
        .status_o(status), .yield_o(yield_s), .id_valid_o(id_valid),
        .id_task_o(id_task), .id_ticks_o(id_ticks)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  tk;
        logic [3:0]  pr;
        logic [15:0] tmo;
        logic [7:0]  run;
        logic [7:0]  dn;
        logic [15:0] st;
        logic        yl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 4'd1,  16'd5,  8'hFE, 8'h00, 16'h0000, 1'b1}, // R3 park
        '{2'd1, 3'd1, 4'd0,  16'd5,  8'hFF, 8'h03, 16'h0000, 1'b0}, // R2 match
        '{2'd1, 3'd2, 4'd3,  16'd0,  8'hFF, 8'h04, 16'h0010, 1'b0}, // R4 poll
        '{2'd0, 3'd3, 4'd9,  16'd7,  8'hFF, 8'h08, 16'h0090, 1'b0}, // R7 bad peer
        '{2'd0, 3'd3, 4'd15, 16'd7,  8'hFF, 8'h08, 16'h0090, 1'b0}, // R7 send to any
        '{2'd0, 3'd4, 4'd6,  16'd50, 8'hEF, 8'h00, 16'h0090, 1'b1}, // R3
        '{2'd0, 3'd5, 4'd6,  16'd50, 8'hCF, 8'h00, 16'h0090, 1'b1}, // R3
        '{2'd0, 3'd2, 4'd6,  16'd50, 8'hCB, 8'h00, 16'h0090, 1'b1}, // R3
        '{2'd1, 3'd6, 4'd15, 16'd9,  8'hCF, 8'h44, 16'h0080, 1'b0}, // R8 lowest
        '{2'd1, 3'd6, 4'd5,  16'd9,  8'hEF, 8'h60, 16'h0080, 1'b0}, // R2 named
        '{2'd0, 3'd4, 4'd4,  16'd0,  8'hEF, 8'h00, 16'h0080, 1'b0}, // R13 ignored
        '{2'd1, 3'd6, 4'd15, 16'd9,  8'hFF, 8'h50, 16'h0080, 1'b0}, // R8
        '{2'd1, 3'd7, 4'd7,  16'd0,  8'hFF, 8'h80, 16'h4080, 1'b0}  // R6 self poll
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] tk, input logic [3:0] pr,
                         input logic [15:0] tmo, input logic with_tick);
        req_valid = 1'b1; req_op = op; req_task = tk; req_peer = pr; req_tmo = tmo;
        tick = with_tick;
        @(negedge clk);
        req_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {32'd0, runnable, done, status}, {32'd0, 8'hFF, 8'h00, 16'h0000});
        chk("R1", {62'd0, yield_s, id_valid}, 64'd0);
        issue(2'd3, 3'd1, 4'd0, 16'd0, 1'b0);
        chk("R1", {52'd0, id_valid, id_task, id_ticks}, {52'd0, 1'b1, 3'd1, 5'(SLICE)});

        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].op, VECS[v].tk, VECS[v].pr, VECS[v].tmo, 1'b0);
            chk($sformatf("vector %0d R2/R3/R4/R6/R7/R8/R13", v),
                {31'd0, runnable, done, status, yield_s},
                {31'd0, VECS[v].run, VECS[v].dn, VECS[v].st, VECS[v].yl});
        end

        // R5 timeout after exactly T ticks
        issue(2'd0, 3'd0, 4'd1, 16'd3, 1'b0);
        chk("R5", {56'd0, runnable}, {56'd0, 8'hFE});
        pulse_tick();
        pulse_tick();
        chk("R5", {48'd0, runnable, done}, {48'd0, 8'hFE, 8'h00});
        pulse_tick();
        chk("R5", {46'd0, runnable, done, status[1:0]}, {46'd0, 8'hFF, 8'h01, 2'd1});

        // R6 self-targeted delay
        issue(2'd1, 3'd7, 4'd7, 16'd2, 1'b0);
        pulse_tick();
        chk("R6", {56'd0, runnable}, {56'd0, 8'h7F});
        pulse_tick();
        chk("R6", {46'd0, runnable, done, status[15:14]}, {46'd0, 8'hFF, 8'h80, 2'd1});

        // R9 match beats expiry in the same cycle
        issue(2'd0, 3'd0, 4'd1, 16'd1, 1'b0);
        chk("R9", {56'd0, runnable}, {56'd0, 8'hFE});
        issue(2'd1, 3'd1, 4'd0, 16'd0, 1'b1);
        chk("R9", {44'd0, runnable, done, status[3:0]}, {44'd0, 8'hFF, 8'h03, 4'd0});

        // R11 yield, then R10 identity after three ticks
        issue(2'd2, 3'd2, 4'd0, 16'd0, 1'b0);
        chk("R11", {63'd0, yield_s}, 64'd1);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        issue(2'd3, 3'd5, 4'd0, 16'd0, 1'b0);
        chk("R10", {55'd0, id_valid, id_task, id_ticks}, {55'd0, 1'b1, 3'd5, 5'(SLICE - 3)});

        // R12 slice expiry
        issue(2'd2, 3'd2, 4'd0, 16'd0, 1'b0);
        for (int k = 0; k < SLICE - 1; k++) pulse_tick();
        chk("R12", {63'd0, yield_s}, 64'd0);
        pulse_tick();
        chk("R12", {63'd0, yield_s}, 64'd1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule